// File: doc/BRIEF.md
# Stepped Soft-Start Controller

This block raises a regulator output from zero volts to its target voltage in two phases, starting when reset is released. In the open-loop phase it drives a PWM duty word that begins at a small width. The word grows by a fixed increment each time a fixed number of clock cycles passes, and this goes on until the voltage ADC delivers its first valid sample. In the closed-loop phase it drives a voltage setpoint for the downstream compensator. The setpoint starts at the measured voltage and climbs in 25 mV steps. Each step waits until a valid sample lies within half a step of the current setpoint.

All voltages use a 6.25 mV LSB. One step is therefore 4 LSB and the settle window is plus or minus 2 LSB. The final step is clamped so that the setpoint lands exactly on the target. Two conditions end the sequence with a fault: the duty reaching its cap with no ADC reading, and a step failing to settle within a bounded number of cycles. Done and fault are both terminal until the next reset.

Top module: `soft_start_ctl`

## Requirements
- R1: While reset is asserted and after it is released, before any clock edge acts, the block shows duty = DUTY_START (4), setpoint = 0, and clActive, done and fault all low.
- R2: In the open-loop phase with adcValid low, duty rises by DUTY_STEP (4) on every RAMP_INTERVAL-th (8th) clock edge after reset release. It holds its value in between.
- R3: The first edge with adcValid high in the open-loop phase makes clActive high and loads setpoint with the lower of adcSample and targetVid. From then on the duty word is frozen.
- R4: In the closed-loop phase, take an edge where adcValid is high, |adcSample - setpoint| <= 2 and setpoint < targetVid. After that edge, setpoint has risen by the lower of 4 and (targetVid - setpoint), so it never passes the target.
- R5: In the closed-loop phase, an edge where adcValid is low, or where the sample differs from setpoint by 3 LSB or more, leaves setpoint unchanged.
- R6: In the closed-loop phase, an edge with a settled sample while setpoint >= targetVid raises done and drops clActive, and setpoint keeps its value.
- R7: Duty never exceeds DUTY_MAX (64). Take an interval edge reached with duty already at DUTY_MAX and adcValid low: after it, fault is high.
- R8: Suppose SETTLE_TIMEOUT (32) consecutive closed-loop edges pass without a settled sample since the last load or step. Then fault goes high after the 32nd such edge, and setpoint holds its value.
- R9: Once done or fault is high, it stays high until reset, and no ADC input moves setpoint or duty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the sequence starts when it is released |
| adcValid | input | 1 | High when adcSample holds a valid conversion |
| adcSample | input | VID_W (10) | Measured output voltage, 6.25 mV per LSB |
| targetVid | input | VID_W (10) | Final voltage, 6.25 mV per LSB |
| olDuty | output | DUTY_W (8) | Open-loop PWM duty word |
| setpoint | output | VID_W (10) | Closed-loop voltage setpoint |
| clActive | output | 1 | High while the closed-loop staircase runs |
| done | output | 1 | Target reached and settled |
| fault | output | 1 | Duty cap reached with no ADC reading, or a step timed out |

## Verification
Every result is registered once, so it shows up on the clock edge after the stimulus that causes it. The bench drives inputs on the falling edge and samples one falling edge after each rising edge it counts. Duty changes and the duty-cap fault are due on edge 8·k after reset release, and the cap fault lands on edge 128. The bench counts edges from the reset release and checks one edge before and one edge at each of these points. The settle timeout is checked after edge 31 and after edge 32 that follow the setpoint load.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'd0,
    ST_CLOSED = 2'd1,
    ST_DONE   = 2'd2,
    ST_FAULT  = 2'd3
  } ssState_t;

  typedef struct packed {
    logic dutyInc;
    logic loadSp;
    logic stepSp;
  } ssStrobe_t;

  typedef struct packed {
    logic settled;
    logic atTarget;
    logic dutyAtMax;
  } ssFlags_t;

endpackage

// File: rtl/ss_dpath.sv
module ss_dpath
  import ss_pkg::*;
#(
  parameter int VID_W      = 10,
  parameter int DUTY_W     = 8,
  parameter int DUTY_START = 4,
  parameter int DUTY_STEP  = 4,
  parameter int DUTY_MAX   = 64,
  parameter int STEP_LSB   = 4,
  parameter int WIN_LSB    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssStrobe_t         strb,
  input  logic              adcValid,
  input  logic [VID_W-1:0]  adcSample,
  input  logic [VID_W-1:0]  targetVid,
  output ssFlags_t          flags,
  output logic [DUTY_W-1:0] duty,
  output logic [VID_W-1:0]  sp
);

  localparam logic [DUTY_W-1:0] DUTY_INIT = DUTY_W'(DUTY_START);
  localparam logic [DUTY_W:0]   DUTY_CAPX = (DUTY_W+1)'(DUTY_MAX);
  localparam logic [DUTY_W:0]   DUTY_INCX = (DUTY_W+1)'(DUTY_STEP);
  localparam logic [VID_W-1:0]  STEP_V    = VID_W'(STEP_LSB);
  localparam logic [VID_W-1:0]  WIN_V     = VID_W'(WIN_LSB);

  logic [DUTY_W:0]  dutySum;
  logic [DUTY_W-1:0] dutyNext;
  logic [VID_W-1:0] diff;
  logic [VID_W-1:0] gap;
  logic [VID_W-1:0] stepAmt;
  logic [VID_W-1:0] loadVal;

  always_comb begin
    dutySum  = {1'b0, duty} + DUTY_INCX;
    dutyNext = (dutySum > DUTY_CAPX) ? DUTY_CAPX[DUTY_W-1:0] : dutySum[DUTY_W-1:0];
    diff     = (adcSample >= sp) ? (adcSample - sp) : (sp - adcSample);
    gap      = (targetVid > sp) ? (targetVid - sp) : '0;
    stepAmt  = (gap < STEP_V) ? gap : STEP_V;
    loadVal  = (adcSample < targetVid) ? adcSample : targetVid;
    flags.settled   = adcValid && (diff <= WIN_V);
    flags.atTarget  = (sp >= targetVid);
    flags.dutyAtMax = ({1'b0, duty} >= DUTY_CAPX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      duty <= DUTY_INIT;
      sp   <= '0;
    end else begin
      if (strb.dutyInc) duty <= dutyNext;
      if (strb.loadSp)      sp <= loadVal;
      else if (strb.stepSp) sp <= sp + stepAmt;
    end
  end

  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, duty} <= DUTY_CAPX) else $error("duty above cap"); // R7

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepSp |=> (sp - $past(sp)) <= STEP_V) else $error("step too large"); // R4

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepSp |=> sp <= $past(targetVid)) else $error("setpoint overshoot"); // R4

  AST_SP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.stepSp && !strb.loadSp) |=> $stable(sp)) else $error("setpoint moved"); // R5

endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int RAMP_INTERVAL  = 8,
  parameter int SETTLE_TIMEOUT = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      adcValid,
  input  ssFlags_t  flags,
  output ssStrobe_t strb,
  output ssState_t  state
);

  localparam int RW = (RAMP_INTERVAL  > 1) ? $clog2(RAMP_INTERVAL)  : 1;
  localparam int TW = (SETTLE_TIMEOUT > 1) ? $clog2(SETTLE_TIMEOUT) : 1;
  localparam logic [RW-1:0] RAMP_LAST   = RW'(RAMP_INTERVAL - 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TIMEOUT - 1);

  ssState_t     stateNext;
  logic [RW-1:0] rampCnt, rampNext;
  logic [TW-1:0] settleCnt, settleNext;

  always_comb begin
    stateNext  = state;
    rampNext   = rampCnt;
    settleNext = settleCnt;
    strb       = '0;
    unique case (state)
      ST_OPEN: begin
        if (adcValid) begin
          strb.loadSp = 1'b1;
          settleNext  = '0;
          stateNext   = ST_CLOSED;
        end else if (rampCnt == RAMP_LAST) begin
          rampNext = '0;
          if (flags.dutyAtMax) stateNext = ST_FAULT;
          else                 strb.dutyInc = 1'b1;
        end else begin
          rampNext = rampCnt + 1'b1;
        end
      end
      ST_CLOSED: begin
        if (flags.settled) begin
          if (flags.atTarget) begin
            stateNext = ST_DONE;
          end else begin
            strb.stepSp = 1'b1;
            settleNext  = '0;
          end
        end else if (settleCnt == SETTLE_LAST) begin
          stateNext = ST_FAULT;
        end else begin
          settleNext = settleCnt + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OPEN;
      rampCnt   <= '0;
      settleCnt <= '0;
    end else begin
      state     <= stateNext;
      rampCnt   <= rampNext;
      settleCnt <= settleNext;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_DONE)) else $error("done left"); // R9

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT) |=> (state == ST_FAULT)) else $error("fault left"); // R9

  AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_CLOSED && state == ST_DONE) |-> $past(flags.atTarget && flags.settled))
    else $error("done without settle at target"); // R6

  AST_LOAD_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSp |=> (state == ST_CLOSED)) else $error("load outside open phase"); // R3

endmodule

// File: rtl/soft_start_ctl.sv
module soft_start_ctl
  import ss_pkg::*;
#(
  parameter int VID_W          = 10,
  parameter int DUTY_W         = 8,
  parameter int DUTY_START     = 4,
  parameter int DUTY_STEP      = 4,
  parameter int DUTY_MAX       = 64,
  parameter int RAMP_INTERVAL  = 8,
  parameter int STEP_LSB       = 4,
  parameter int WIN_LSB        = 2,
  parameter int SETTLE_TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcValid,
  input  logic [VID_W-1:0]  adcSample,
  input  logic [VID_W-1:0]  targetVid,
  output logic [DUTY_W-1:0] olDuty,
  output logic [VID_W-1:0]  setpoint,
  output logic              clActive,
  output logic              done,
  output logic              fault
);

  ssStrobe_t strb;
  ssFlags_t  flags;
  ssState_t  state;

  ss_ctrl #(
    .RAMP_INTERVAL (RAMP_INTERVAL),
    .SETTLE_TIMEOUT(SETTLE_TIMEOUT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .adcValid(adcValid),
    .flags   (flags),
    .strb    (strb),
    .state   (state)
  );

  ss_dpath #(
    .VID_W     (VID_W),
    .DUTY_W    (DUTY_W),
    .DUTY_START(DUTY_START),
    .DUTY_STEP (DUTY_STEP),
    .DUTY_MAX  (DUTY_MAX),
    .STEP_LSB  (STEP_LSB),
    .WIN_LSB   (WIN_LSB)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .adcValid (adcValid),
    .adcSample(adcSample),
    .targetVid(targetVid),
    .flags    (flags),
    .duty     (olDuty),
    .sp       (setpoint)
  );

  assign clActive = (state == ST_CLOSED);
  assign done     = (state == ST_DONE);
  assign fault    = (state == ST_FAULT);

  AST_DUTY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_OPEN) |=> $stable(olDuty)) else $error("duty moved after open phase"); // R3

endmodule

// File: tb/soft_start_ctl_bench.sv
module soft_start_ctl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       adcValid = 1'b0;
  logic [9:0] adcSample = '0;
  logic [9:0] targetVid = '0;
  logic [7:0] olDuty;
  logic [9:0] setpoint;
  logic       clActive, done, fault;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  soft_start_ctl u_soft_start_ctl (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .adcSample(adcSample),
    .targetVid(targetVid), .olDuty(olDuty), .setpoint(setpoint),
    .clActive(clActive), .done(done), .fault(fault)
  );

  // vector: {valid, sample[9:0], expSp[9:0], expCl, expDone}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 10'd10, 10'd10, 1'b1, 1'b0},  // R3 load from open phase
    {1'b1, 10'd10, 10'd14, 1'b1, 1'b0},  // R4 settled, step
    {1'b0, 10'd14, 10'd14, 1'b1, 1'b0},  // R5 not valid
    {1'b1, 10'd17, 10'd14, 1'b1, 1'b0},  // R5 +3 outside window
    {1'b1, 10'd11, 10'd14, 1'b1, 1'b0},  // R5 -3 outside window
    {1'b1, 10'd16, 10'd18, 1'b1, 1'b0},  // R4 +2 edge of window
    {1'b1, 10'd16, 10'd22, 1'b1, 1'b0},  // R4 -2 edge of window
    {1'b1, 10'd22, 10'd26, 1'b1, 1'b0},  // R4
    {1'b1, 10'd26, 10'd30, 1'b1, 1'b0},  // R4
    {1'b1, 10'd30, 10'd34, 1'b1, 1'b0},  // R4
    {1'b1, 10'd34, 10'd38, 1'b1, 1'b0},  // R4
    {1'b1, 10'd36, 10'd40, 1'b1, 1'b0},  // R4 clamped last step
    {1'b1, 10'd41, 10'd40, 1'b0, 1'b1},  // R6 settled at target
    {1'b1, 10'd0,  10'd40, 1'b0, 1'b1}   // R9 done holds
  };

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic [9:0] tgt);
    @(negedge clk);
    rstN = 1'b0; adcValid = 1'b0; adcSample = '0; targetVid = tgt;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset(10'd40);
    chk("R1 duty", olDuty, 4);
    chk("R1 setpoint", setpoint, 0);
    chk("R1 flags", {clActive, done, fault}, 0);

    // staircase table, after 3 open-loop edges
    edges(3);
    for (int i = 0; i < NV; i++) begin
      adcValid  = VEC[i][22];
      adcSample = VEC[i][21:12];
      edges(1);
      chk($sformatf("R4/R5/R6 vec %0d setpoint", i), setpoint, VEC[i][11:2]);
      chk($sformatf("R6 vec %0d clActive", i), clActive, VEC[i][1]);
      chk($sformatf("R6 vec %0d done", i), done, VEC[i][0]);
      chk($sformatf("R3 vec %0d duty frozen", i), olDuty, 4);
    end

    // R2 ramp timing
    doReset(10'd40);
    edges(7);
    chk("R2 duty before first tick", olDuty, 4);
    edges(1);
    chk("R2 duty after first tick", olDuty, 8);
    edges(7);
    chk("R2 duty held between ticks", olDuty, 8);
    edges(1);
    chk("R2 duty after second tick", olDuty, 12);

    // R7 duty cap and fault (already 16 edges in)
    edges(111);
    chk("R7 duty capped", olDuty, 64);
    chk("R7 no fault yet", fault, 0);
    edges(1);
    chk("R7 fault at cap tick", fault, 1);
    chk("R7 duty stays capped", olDuty, 64);
    // R9 fault terminal
    adcValid = 1'b1; adcSample = 10'd5;
    edges(4);
    chk("R9 fault sticky", fault, 1);
    chk("R9 setpoint untouched in fault", setpoint, 0);
    chk("R9 clActive low in fault", clActive, 0);

    // R8 settle timeout
    doReset(10'd40);
    edges(3);
    adcValid = 1'b1; adcSample = 10'd10;
    edges(1);
    chk("R8 loaded setpoint", setpoint, 10);
    adcSample = 10'd20;
    edges(31);
    chk("R8 no fault before timeout", fault, 0);
    edges(1);
    chk("R8 fault at timeout", fault, 1);
    chk("R8 setpoint held", setpoint, 10);
    adcSample = 10'd10;
    edges(2);
    chk("R9 settled sample ignored in fault", setpoint, 10);
    chk("R9 duty unchanged in fault", olDuty, 4);

    // R3 load clamped to target, then R6 immediate done
    doReset(10'd20);
    adcValid = 1'b1; adcSample = 10'd30;
    edges(1);
    chk("R3 load clamped to target", setpoint, 20);
    chk("R3 clActive", clActive, 1);
    adcSample = 10'd21;
    edges(1);
    chk("R6 done at target", done, 1);
    chk("R6 setpoint kept", setpoint, 20);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule